// File: doc/BRIEF.md
# Shared Hot-Pin Thermal Throttle Controller

This block decides how a two-core package throttles itself when it overheats. The package has one hot pin, which is active-low, open-drain and bidirectional. The block pulls the pin low whenever either core reports a thermal trip. It also samples the pin, so a device outside the package that pulls the pin low forces throttling as well. The sampled pin level passes through a two-flop synchronizer before any logic uses it.

Two throttle policies can be enabled separately:
- **Duty policy.** Each affected core gets an on/off clock-enable pattern. The pattern repeats over a fixed period, and software sets how many cycles of each period the clock runs. Only the tripped core is gated. If the pin is held active with no core tripped, both cores are gated.
- **State policy.** A low performance-state request goes out for the whole package. When both policies are enabled, the duty gating waits until the request has been acknowledged.

Separately enabled single-cycle interrupts mark each assertion and each deassertion of the synchronized pin.

Top module: `thermctl_top`

## Requirements
- R1: `pin_drive_o` is high (pulling the pin low) in the cycle after any bit of `core_trip_i` is high, and low in the cycle after all bits are low.
- R2: The pin level reaches the control logic only through a two-flop synchronizer. A pull that starts at a clock edge shows on `pstate_req_o` at the third edge, and not earlier.
- R3: With both policy enables low, an active pin leaves `core_clk_en_o` all ones and `pstate_req_o` low.
- R4: With only the duty policy enabled and the synchronized pin active, a tripped core's clock enable is high only in the first `duty_on_i` cycles of each `PERIOD`-cycle window. The windows are counted from reset. A core that has not tripped keeps its enable high. A `duty_on_i` of at least `PERIOD` never gates.
- R5: When the synchronized pin is active and no core has tripped (an outside pull), the duty policy gates both cores.
- R6: `pstate_req_o` is high in the cycle after the state policy is enabled while the synchronized pin is active, regardless of which core tripped.
- R7: With both policies enabled, no core is gated while `pstate_req_o` is high and no `pstate_ack_i` has yet been seen for that request. After an acknowledge, duty gating applies as in R4.
- R8: `irq_assert_o` pulses for exactly one cycle, the cycle after the synchronized pin goes from idle to active, but only if `irq_assert_en_i` is high.
- R9: `irq_deassert_o` pulses for exactly one cycle, the cycle after the synchronized pin goes from active to idle, but only if `irq_deassert_en_i` is high.
- R10: After a synchronous reset: `pin_drive_o` = 0, `core_clk_en_o` = all ones, `pstate_req_o` = 0, both interrupts = 0, and the duty window restarts at cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_trip_i | input | NUM_CORES | Per-core thermal trip flags |
| hot_pin_n_i | input | 1 | Sampled level of the shared hot pin (low = active) |
| duty_en_i | input | 1 | Enables the duty (clock-modulation) policy |
| state_en_i | input | 1 | Enables the low performance-state policy |
| duty_on_i | input | DUTY_W | Clock-on cycles per modulation window |
| pstate_ack_i | input | 1 | Acknowledge that the low performance state has been reached |
| irq_assert_en_i | input | 1 | Enables the interrupt on pin assertion |
| irq_deassert_en_i | input | 1 | Enables the interrupt on pin deassertion |
| pin_drive_o | output | 1 | Open-drain pull-down enable for the hot pin |
| core_clk_en_o | output | NUM_CORES | Per-core clock enables |
| pstate_req_o | output | 1 | Request for the lowest programmed performance state |
| irq_assert_o | output | 1 | One-cycle pulse on pin assertion |
| irq_deassert_o | output | 1 | One-cycle pulse on pin deassertion |

## Verification
The main function is tried with four kinds of pin activity:
- **A trip on one core**, where the pin is driven by the block itself. This separates gating of the hot core only from gating of both cores.
- **A pull from outside with no trip.** This shows that throttling is forced on both cores with no core identified.
- **Both sources at once.** This shows that a trip still gives a per-core mask.
- **Each source under each policy enable combination**, including both policies with and without an acknowledge.

The duty input is swept across 0, a mid value and the full period, to separate gating that is always on, gating with a pattern, and no gating. The interrupt enables are toggled around pin edges to show that each edge is reported only when its enable is set.

// File: rtl/thermctl_pkg.sv
package thermctl_pkg;
  // Policy selection carried between the top and the policy unit
  typedef struct packed {
    logic duty;   // per-core clock duty gating
    logic state;  // package-wide low performance-state request
  } tc_policy_t;
endpackage

// File: rtl/thermctl_pin_io.sv
module thermctl_pin_io #(
  parameter int NUM_CORES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] core_trip_i,
  input  logic                 pin_n_i,
  input  logic                 rise_en_i,
  input  logic                 fall_en_i,
  output logic                 drive_o,
  output logic                 pin_act_o,
  output logic                 irq_rise_o,
  output logic                 irq_fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  // Open-drain pull-down: asserted whenever any core is hot
  always_ff @(posedge clk) begin
    if (rst) drive_o <= 1'b0;
    else     drive_o <= |core_trip_i;
  end

  // Synchronizer chain, bit 0 captures the inverted (active-high) pin
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ~pin_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ~pin_n_i};
      end
    end
  endgenerate

  assign pin_act_o = sync_q[SYNC_STAGES-1];

  // Edge detection and interrupt pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      last_q     <= 1'b0;
      irq_rise_o <= 1'b0;
      irq_fall_o <= 1'b0;
    end else begin
      last_q     <= pin_act_o;
      irq_rise_o <= rise_en_i &  pin_act_o & ~last_q;
      irq_fall_o <= fall_en_i & ~pin_act_o &  last_q;
    end
  end

  p_drive_on_trip_r1: assert property (@(posedge clk) disable iff (rst)
    (|core_trip_i) |=> drive_o);
  p_drive_off_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !(|core_trip_i) |=> !drive_o);
  p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
    irq_rise_o |=> !irq_rise_o);
  p_rise_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq_rise_o |-> $past(pin_act_o));
  p_fall_single_r9: assert property (@(posedge clk) disable iff (rst)
    irq_fall_o |=> !irq_fall_o);
  p_fall_level_r9: assert property (@(posedge clk) disable iff (rst)
    irq_fall_o |-> !$past(pin_act_o));
endmodule

// File: rtl/thermctl_duty.sv
module thermctl_duty #(
  parameter int PERIOD = 8,
  localparam int CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1,
  localparam int DUTY_W = $clog2(PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_on_i,
  output logic              on_phase_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  // Free-running window counter, restarted by reset
  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign on_phase_o = {{(DUTY_W > CNT_W ? 1 : CNT_W - DUTY_W + 1){1'b0}}, cnt_q}
                      < {{(CNT_W >= DUTY_W ? 1 : DUTY_W - CNT_W + 1){1'b0}}, duty_on_i};

  p_cnt_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> (cnt_q == '0));
  p_full_duty_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(duty_on_i) >= PERIOD) |-> on_phase_o);
endmodule

// File: rtl/thermctl_policy.sv
module thermctl_policy
  import thermctl_pkg::*;
#(
  parameter int NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pin_act_i,
  input  logic [NUM_CORES-1:0] core_trip_i,
  input  tc_policy_t           policy_i,
  input  logic                 ack_i,
  input  logic                 on_phase_i,
  output logic [NUM_CORES-1:0] clk_en_o,
  output logic                 req_o
);
  logic [NUM_CORES-1:0] trip_q;
  logic [NUM_CORES-1:0] hot_mask;
  logic                 acked_q;
  logic                 gate_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      trip_q  <= '0;
      req_o   <= 1'b0;
      acked_q <= 1'b0;
    end else begin
      trip_q  <= core_trip_i;
      req_o   <= policy_i.state & pin_act_i;
      acked_q <= req_o & (acked_q | ack_i);
    end
  end

  // No core identified as hot means the pin was pulled from outside
  assign hot_mask    = (|trip_q) ? trip_q : '1;
  assign gate_active = pin_act_i & policy_i.duty & (~policy_i.state | acked_q);

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      always_ff @(posedge clk) begin
        if (rst) clk_en_o[c] <= 1'b1;
        else     clk_en_o[c] <= ~(gate_active & hot_mask[c] & ~on_phase_i);
      end
    end
  endgenerate

  p_no_policy_r3: assert property (@(posedge clk) disable iff (rst)
    (!policy_i.duty && !policy_i.state) |=> (clk_en_o == '1 && !req_o));
  p_req_needs_state_r6: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $past(policy_i.state && pin_act_i));
  p_hold_off_r7: assert property (@(posedge clk) disable iff (rst)
    (policy_i.state && !acked_q) |=> (clk_en_o == '1));
  p_ext_both_r5: assert property (@(posedge clk) disable iff (rst)
    (pin_act_i && policy_i.duty && !policy_i.state && trip_q == '0 && !on_phase_i)
    |=> (clk_en_o == '0));
endmodule

// File: rtl/thermctl_top.sv
module thermctl_top
  import thermctl_pkg::*;
#(
  parameter int NUM_CORES   = 2,
  parameter int PERIOD      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DUTY_W     = $clog2(PERIOD + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] core_trip_i,
  input  logic                 hot_pin_n_i,
  input  logic                 duty_en_i,
  input  logic                 state_en_i,
  input  logic [DUTY_W-1:0]    duty_on_i,
  input  logic                 pstate_ack_i,
  input  logic                 irq_assert_en_i,
  input  logic                 irq_deassert_en_i,
  output logic                 pin_drive_o,
  output logic [NUM_CORES-1:0] core_clk_en_o,
  output logic                 pstate_req_o,
  output logic                 irq_assert_o,
  output logic                 irq_deassert_o
);
  logic       pin_act;
  logic       on_phase;
  tc_policy_t policy;

  assign policy.duty  = duty_en_i;
  assign policy.state = state_en_i;

  thermctl_pin_io #(.NUM_CORES(NUM_CORES), .SYNC_STAGES(SYNC_STAGES)) i_pin (
    .clk(clk), .rst(rst), .core_trip_i(core_trip_i), .pin_n_i(hot_pin_n_i),
    .rise_en_i(irq_assert_en_i), .fall_en_i(irq_deassert_en_i),
    .drive_o(pin_drive_o), .pin_act_o(pin_act),
    .irq_rise_o(irq_assert_o), .irq_fall_o(irq_deassert_o));

  thermctl_duty #(.PERIOD(PERIOD)) i_duty (
    .clk(clk), .rst(rst), .duty_on_i(duty_on_i), .on_phase_o(on_phase));

  thermctl_policy #(.NUM_CORES(NUM_CORES)) i_policy (
    .clk(clk), .rst(rst), .pin_act_i(pin_act), .core_trip_i(core_trip_i),
    .policy_i(policy), .ack_i(pstate_ack_i), .on_phase_i(on_phase),
    .clk_en_o(core_clk_en_o), .req_o(pstate_req_o));

  p_reset_state_r10: assert property (@(posedge clk)
    $past(rst) |-> (!pin_drive_o && core_clk_en_o == '1 && !pstate_req_o
                    && !irq_assert_o && !irq_deassert_o));
endmodule

// File: tb/test_thermctl_top.sv
module test_thermctl_top;
  localparam int NC = 2;
  localparam int PER = 8;
  localparam int DW = $clog2(PER + 1);

  logic clk = 0, rst = 1;
  logic [NC-1:0] trip = '0;
  logic ext_pull = 0;
  logic duty_en = 0, state_en = 0, ack = 0, ra_en = 0, fa_en = 0;
  logic [DW-1:0] duty_on = '0;
  logic pin_n;
  logic drive, req, irq_a, irq_d;
  logic [NC-1:0] clk_en;

  int checks = 0, fails = 0;
  bit started = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign pin_n = ~(drive | ext_pull);

  thermctl_top #(.NUM_CORES(NC), .PERIOD(PER)) i_thermctl_top (
    .clk(clk), .rst(rst), .core_trip_i(trip), .hot_pin_n_i(pin_n),
    .duty_en_i(duty_en), .state_en_i(state_en), .duty_on_i(duty_on),
    .pstate_ack_i(ack), .irq_assert_en_i(ra_en), .irq_deassert_en_i(fa_en),
    .pin_drive_o(drive), .core_clk_en_o(clk_en), .pstate_req_o(req),
    .irq_assert_o(irq_a), .irq_deassert_o(irq_d));

  // Behavioural reference model
  int m_drive, m_s1, m_s2, m_prev, m_req, m_acked, m_ia, m_id, m_cyc;
  int m_trip;
  int m_en [NC];

  always @(posedge clk) begin
    int act, on, mask, gate;
    int n_drive, n_s1, n_s2, n_prev, n_req, n_acked, n_ia, n_id, n_trip;
    int n_en [NC];
    started = 1;
    if (rst) begin
      m_drive = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_req = 0; m_acked = 0;
      m_ia = 0; m_id = 0; m_cyc = 0; m_trip = 0;
      for (int c = 0; c < NC; c++) m_en[c] = 1;
    end else begin
      act  = (m_drive != 0 || ext_pull) ? 1 : 0;
      on   = ((m_cyc % PER) < int'(duty_on)) ? 1 : 0;
      mask = (m_trip != 0) ? m_trip : (1 << NC) - 1;
      gate = (m_s2 && duty_en && (!state_en || m_acked)) ? 1 : 0;
      n_drive = (trip != 0) ? 1 : 0;
      n_s1 = act; n_s2 = m_s1; n_prev = m_s2;
      n_ia = (ra_en && m_s2 && !m_prev) ? 1 : 0;
      n_id = (fa_en && !m_s2 && m_prev) ? 1 : 0;
      n_req = (state_en && m_s2) ? 1 : 0;
      n_acked = (m_req && (m_acked || ack)) ? 1 : 0;
      n_trip = int'(trip);
      for (int c = 0; c < NC; c++)
        n_en[c] = (gate && ((mask >> c) & 1) && !on) ? 0 : 1;
      m_drive = n_drive; m_s1 = n_s1; m_s2 = n_s2; m_prev = n_prev;
      m_ia = n_ia; m_id = n_id; m_req = n_req; m_acked = n_acked;
      m_trip = n_trip; m_cyc = m_cyc + 1;
      for (int c = 0; c < NC; c++) m_en[c] = n_en[c];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      int e;
      e = 0;
      for (int c = 0; c < NC; c++) e |= (m_en[c] << c);
      chk("R1 pin_drive_o", int'(drive), m_drive);
      chk("R4 core_clk_en_o", int'(clk_en), e);
      chk("R6 pstate_req_o", int'(req), m_req);
      chk("R8 irq_assert_o", int'(irq_a), m_ia);
      chk("R9 irq_deassert_o", int'(irq_d), m_id);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    trip = '0; ext_pull = 0; ack = 0;
    step(8);
  endtask

  initial begin
    step(3);
    rst = 0;
    // R10: reset state
    chk("R10 drive", int'(drive), 0);
    chk("R10 clk_en", int'(clk_en), 3);
    chk("R10 req", int'(req), 0);
    chk("R10 irqs", int'(irq_a | irq_d), 0);

    // R3: no policy, outside pull has no throttling effect
    ext_pull = 1; step(10);
    chk("R3 clk_en no policy", int'(clk_en), 3);
    chk("R3 req no policy", int'(req), 0);
    quiet();

    // R1/R4: duty policy, core 0 hot, mid duty
    duty_en = 1; duty_on = DW'(3); ra_en = 1; fa_en = 1;
    trip = 2'b01; step(1);
    chk("R1 drive after trip", int'(drive), 1);
    step(20);
    chk("R4 cold core untouched", int'(clk_en[1]), 1);
    trip = '0; step(10);
    // R4: full duty never gates, both cores hot
    duty_on = DW'(PER); trip = 2'b11; step(20);
    chk("R4 full duty", int'(clk_en), 3);
    quiet();

    // R5: outside pull, no trip, zero duty -> both gated
    duty_on = '0; ext_pull = 1; step(10);
    chk("R5 both cores gated", int'(clk_en), 0);
    quiet();
    // mixed: trip core 1 plus outside pull
    trip = 2'b10; ext_pull = 1; step(10);
    chk("R4 only tripped core", int'(clk_en), 1);
    quiet();

    // R2/R6: state policy only, synchronizer latency
    duty_en = 0; state_en = 1;
    ext_pull = 1; step(2);
    chk("R2 req not before third edge", int'(req), 0);
    step(1);
    chk("R2 req at third edge", int'(req), 1);
    step(5);
    chk("R6 clk_en under state only", int'(clk_en), 3);
    quiet();
    chk("R6 req drops", int'(req), 0);

    // R7: both policies, hold-off until acknowledge
    duty_en = 1; duty_on = '0; trip = 2'b01; step(12);
    chk("R7 held off", int'(clk_en), 3);
    chk("R7 req up", int'(req), 1);
    ack = 1; step(1); ack = 0; step(3);
    chk("R7 gated after ack", int'(clk_en), 2);
    quiet();

    // R8/R9: interrupt enables off
    ra_en = 0; fa_en = 0; state_en = 0;
    ext_pull = 1; step(6);
    chk("R8 no assert irq when disabled", int'(irq_a), 0);
    ext_pull = 0; step(6);
    chk("R9 no deassert irq when disabled", int'(irq_d), 0);
    // only deassert enabled, exact pulse cycle
    fa_en = 1; ext_pull = 1; step(6); ext_pull = 0; step(3);
    chk("R9 deassert pulse", int'(irq_d), 1);
    step(1);
    chk("R9 single cycle", int'(irq_d), 0);
    ra_en = 1; ext_pull = 1; step(3);
    chk("R8 assert pulse", int'(irq_a), 1);
    quiet();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule